// File: doc/BRIEF.md
# Form Skip-Over Paper Feed Controller

This block decides when a line printer moves its paper. In the ordinary case it advances exactly one line after each read-start strobe. On multi-part forms such as invoices, it can also skip the repeated header area of the next copy. A hole punched in an arm channel of the carriage control tape marks the last body line of a form. When the paper reaches that hole on the advance that follows a print cycle, an arm latch is set.

If the next record read in carries no explicit skip-over feed symbol, the block starts a continuous feed. It keeps requesting paper motion, line after line, until a hole in a separate stop channel passes the sensing brush. That stop hole sits on the first body line of the following copy. At that line the arm latch clears, the motion request drops and a normal print cycle can follow.

A record that does carry the explicit feed symbol, such as a closing total line, overrides the armed skip. Paper position is reported to the block only by a line-step pulse. The tape channels are sampled on that pulse and only while motion is requested. The motor, clutch and brake drivers are outside the block.

Top module: `form_skip_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block leaves that edge with `feed_req` at 0, `ready` at 1, the arm latch clear and no print cycle pending.
- R2: `read_start` seen while `ready` is 1 raises `feed_req` at the next edge. `feed_req` then falls, and `ready` returns, at the edge after the first `line_step`.
- R3: The arm latch is set only when the `line_step` that ends a one-line advance shows a hole on the arm channel, and only if `print_done` was seen while ready before that advance began. The same hole met on an advance without a preceding `print_done` leaves the block unarmed.
- R4: `rec_valid` with `rec_sym` at 0, seen while ready and armed, starts a skip. `feed_req` is 1 from the next edge on.
- R5: During a skip, `feed_req` stays 1 across every `line_step` whose stop-channel bit is 0, including steps over the arm-channel hole.
- R6: The first `line_step` during a skip whose stop-channel bit is 1 clears `feed_req` and the arm latch at the next edge. On a 70-line loop armed at line 68 with the stop hole at line 20, the paper stops at line 20 after 22 steps.
- R7: `rec_valid` with `rec_sym` at 1 starts no motion, even when armed, and clears the arm latch.
- R8: `rec_valid` with `rec_sym` at 0 while not armed starts no motion.
- R9: While `ready` is 1, `line_step` and `tape_chan` have no effect. A stop hole does not clear the arm latch and an arm hole does not set it.
- R10: When an armed skip start and `read_start` arrive in the same cycle, the skip wins and runs to the stop hole.
- R11: `read_start`, `rec_valid` and `print_done` seen while `feed_req` is 1 are ignored.
- R12: The arm channel is bit `ARM_CH` and the stop channel is bit `STOP_CH` of `tape_chan`. The defaults, 4 and 5, are tape channels 5 and 6 counted from one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_step | input | 1 | One-cycle pulse when the paper has arrived at a new line |
| tape_chan | input | NUM_CHAN | Carriage tape channel brushes at the new line, valid with `line_step` |
| print_done | input | 1 | One-cycle strobe at the end of a print cycle |
| read_start | input | 1 | One-cycle strobe asking for a single line advance |
| rec_valid | input | 1 | One-cycle strobe when a new record has been read in |
| rec_sym | input | 1 | The record read in carries an explicit skip-over feed symbol |
| feed_req | output | 1 | Paper motion request |
| ready | output | 1 | Paper stopped, block accepts new strobes |

## Verification
The bench builds the block with its defaults: 12 tape channels, the arm hole on bit 4 and the stop hole on bit 5. It models a 70-line loop with an arm hole at line 68 and a stop hole at line 20. This brings the full 22-line skip across the loop wrap within reach, as well as arming on the last body line after every run of printed lines. A seeded random phase mixes advances with and without print cycles, records with and without the feed symbol, and idle line pulses with random channel bits. Each outcome is compared with a bench model of the arm latch and paper position.

// File: rtl/form_skip_pkg.sv
// Shared types for the form skip-over feed controller.
package form_skip_pkg;

    // Paper motion state: stopped, one-line advance, continuous skip.
    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_LINE = 2'd1,
        FS_SKIP = 2'd2
    } fs_state_e;

endpackage

// File: rtl/fsk_chan_sense.sv
// Tape channel qualifier.
// Picks the arm and stop bits out of the carriage tape channel vector and
// passes them on only during a line-step pulse while paper is moving.
// Assumes tape_chan is valid in the same cycle as line_step.
module fsk_chan_sense #(
    parameter int NUM_CHAN = 12,
    parameter int ARM_CH   = 4,
    parameter int STOP_CH  = 5
) (
    input  logic                line_step,
    input  logic                moving,
    input  logic [NUM_CHAN-1:0] tape_chan,
    output logic                arm_seen,
    output logic                stop_seen
);
    localparam logic [NUM_CHAN-1:0] ARM_MASK  = NUM_CHAN'(1) << ARM_CH;
    localparam logic [NUM_CHAN-1:0] STOP_MASK = NUM_CHAN'(1) << STOP_CH;

    logic sample_en;

    // Channels count only on a line step during motion.
    always_comb begin
        sample_en = line_step & moving;
        arm_seen  = sample_en & (|(tape_chan & ARM_MASK));
        stop_seen = sample_en & (|(tape_chan & STOP_MASK));
    end
endmodule

// File: rtl/fsk_arm_latch.sv
// Skip arm latch.
// Set by a qualified arm-channel hole, cleared by the stop hole or by a
// record that carries its own feed symbol. Clear wins over set.
module fsk_arm_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic arm_q
);
    // Holds the armed condition between the form end and the next record.
    always_ff @(posedge clk) begin
        if (!rst_n)      arm_q <= 1'b0;
        else if (clr_i)  arm_q <= 1'b0;
        else if (set_i)  arm_q <= 1'b1;
    end
endmodule

// File: rtl/fsk_sequencer.sv
// Paper motion sequencer.
// Accepts strobes only while stopped. It runs a one-line advance on
// read_start, and a continuous skip when an armed record arrives without a
// feed symbol. A print cycle seen while stopped marks the next advance as
// eligible for arming.
module fsk_sequencer
    import form_skip_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic read_start,
    input  logic print_done,
    input  logic rec_valid,
    input  logic rec_sym,
    input  logic line_step,
    input  logic arm_q,
    input  logic arm_seen,
    input  logic stop_seen,
    output logic arm_set,
    output logic arm_clr,
    output logic moving,
    output logic skip_active
);
    fs_state_e state_q, state_d;
    logic      pend_q, pend_d;

    // Next state, pending print flag and arm latch controls.
    always_comb begin
        state_d = state_q;
        pend_d  = pend_q;
        arm_set = 1'b0;
        arm_clr = 1'b0;
        unique case (state_q)
            FS_IDLE: begin
                if (print_done) pend_d = 1'b1;
                if (rec_valid && rec_sym) begin
                    arm_clr = 1'b1;
                end
                if (rec_valid && !rec_sym && arm_q) begin
                    state_d = FS_SKIP;
                end else if (read_start) begin
                    state_d = FS_LINE;
                end
            end
            FS_LINE: begin
                if (line_step) begin
                    arm_set = pend_q & arm_seen;
                    pend_d  = 1'b0;
                    state_d = FS_IDLE;
                end
            end
            FS_SKIP: begin
                if (stop_seen) begin
                    arm_clr = 1'b1;
                    state_d = FS_IDLE;
                end
            end
            default: state_d = FS_IDLE;
        endcase
    end

    // State and pending print registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FS_IDLE;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
        end
    end

    // Decoded state views for the outputs and the channel qualifier.
    always_comb begin
        moving      = (state_q != FS_IDLE);
        skip_active = (state_q == FS_SKIP);
    end
endmodule

// File: rtl/form_skip_ctrl.sv
// Form skip-over paper feed controller, top level.
// Ties together the channel qualifier, the arm latch and the sequencer.
// Assumes all strobes are single-cycle pulses synchronous to clk.
module form_skip_ctrl #(
    parameter int NUM_CHAN = 12,
    parameter int ARM_CH   = 4,
    parameter int STOP_CH  = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                line_step,
    input  logic [NUM_CHAN-1:0] tape_chan,
    input  logic                print_done,
    input  logic                read_start,
    input  logic                rec_valid,
    input  logic                rec_sym,
    output logic                feed_req,
    output logic                ready
);
    logic arm_seen, stop_seen;
    logic arm_set, arm_clr, arm_q;
    logic moving, skip_active;

    fsk_chan_sense #(
        .NUM_CHAN (NUM_CHAN),
        .ARM_CH   (ARM_CH),
        .STOP_CH  (STOP_CH)
    ) u_sense (
        .line_step (line_step),
        .moving    (moving),
        .tape_chan (tape_chan),
        .arm_seen  (arm_seen),
        .stop_seen (stop_seen)
    );

    fsk_arm_latch u_arm (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (arm_set),
        .clr_i (arm_clr),
        .arm_q (arm_q)
    );

    fsk_sequencer u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .read_start  (read_start),
        .print_done  (print_done),
        .rec_valid   (rec_valid),
        .rec_sym     (rec_sym),
        .line_step   (line_step),
        .arm_q       (arm_q),
        .arm_seen    (arm_seen),
        .stop_seen   (stop_seen),
        .arm_set     (arm_set),
        .arm_clr     (arm_clr),
        .moving      (moving),
        .skip_active (skip_active)
    );

    // Port views of the motion state.
    always_comb begin
        feed_req = moving;
        ready    = !moving;
    end
endmodule

// File: rtl/form_skip_ctrl_chk.sv
// Property checker for form_skip_ctrl, attached by bind below.
module form_skip_ctrl_chk #(
    parameter int NUM_CHAN = 12,
    parameter int STOP_CH  = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                line_step,
    input logic [NUM_CHAN-1:0] tape_chan,
    input logic                read_start,
    input logic                rec_valid,
    input logic                rec_sym,
    input logic                feed_req,
    input logic                ready,
    input logic                arm_q,
    input logic                skip_active
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!feed_req && ready && !arm_q)); // R1

    AST_START_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && read_start) |=> feed_req); // R2

    AST_ARM_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arm_q) |-> $past(line_step)); // R3

    AST_SKIP_START: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && arm_q && rec_valid && !rec_sym) |=> (feed_req && skip_active)); // R4

    AST_SKIP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (skip_active && !(line_step && tape_chan[STOP_CH])) |=> skip_active); // R5

    AST_STOP_HOLE: assert property (@(posedge clk) disable iff (!rst_n)
        (skip_active && line_step && tape_chan[STOP_CH]) |=> (!feed_req && !arm_q)); // R6

    AST_SYM_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && rec_valid && rec_sym && !read_start) |=> (ready && !arm_q)); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !read_start && !rec_valid) |=> (ready && $stable(arm_q))); // R9
endmodule

bind form_skip_ctrl form_skip_ctrl_chk #(
    .NUM_CHAN (NUM_CHAN),
    .STOP_CH  (STOP_CH)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_step   (line_step),
    .tape_chan   (tape_chan),
    .read_start  (read_start),
    .rec_valid   (rec_valid),
    .rec_sym     (rec_sym),
    .feed_req    (feed_req),
    .ready       (ready),
    .arm_q       (arm_q),
    .skip_active (skip_active)
);

// File: tb/form_skip_ctrl_tb.sv
module form_skip_ctrl_tb;
    localparam int NCH      = 12;
    localparam int LOOP_LEN = 70;
    localparam int ARM_LINE = 68;
    localparam int STOP_LINE = 20;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           line_step = 1'b0;
    logic [NCH-1:0] tape_chan = '0;
    logic           print_done = 1'b0;
    logic           read_start = 1'b0;
    logic           rec_valid = 1'b0;
    logic           rec_sym = 1'b0;
    logic           feed_req, ready;

    int checks = 0;
    int errors = 0;
    int pos = 60;
    bit exp_arm = 1'b0;

    always #2 clk = ~clk;

    form_skip_ctrl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_step  (line_step),
        .tape_chan  (tape_chan),
        .print_done (print_done),
        .read_start (read_start),
        .rec_valid  (rec_valid),
        .rec_sym    (rec_sym),
        .feed_req   (feed_req),
        .ready      (ready)
    );

    function automatic logic [NCH-1:0] holes(input int line);
        logic [NCH-1:0] h = '0;
        if (line == ARM_LINE)  h[4] = 1'b1;
        if (line == STOP_LINE) h[5] = 1'b1;
        return h;
    endfunction

    function automatic int next_line(input int line);
        return (line == LOOP_LEN) ? 1 : line + 1;
    endfunction

    function automatic int skip_len(input int from);
        int d = (STOP_LINE - from + LOOP_LEN) % LOOP_LEN;
        return (d == 0) ? LOOP_LEN : d;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (line %0d)", req, act, exp, pos);
        end
    endtask

    task automatic step_line();
        @(negedge clk);
        pos = next_line(pos);
        tape_chan = holes(pos);
        line_step = 1'b1;
        @(negedge clk);
        line_step = 1'b0;
        tape_chan = '0;
    endtask

    task automatic print_advance(input bit do_print);
        if (do_print) begin
            @(negedge clk) print_done = 1'b1;
            @(negedge clk) print_done = 1'b0;
        end
        @(negedge clk) read_start = 1'b1;
        @(negedge clk) read_start = 1'b0;
        chk("R2 feed raised", feed_req, 1);
        step_line();
        chk("R2 feed dropped", feed_req, 0);
        chk("R2 ready back", ready, 1);
        if (do_print && pos == ARM_LINE) exp_arm = 1'b1;
    endtask

    task automatic goto_line(input int line);
        while (pos != line) print_advance(1'b0);
    endtask

    // Step the paper while motion is requested; optionally inject strobes.
    task automatic run_skip(input bit inject, input string req);
        int steps = 0;
        int want = skip_len(pos);
        while (feed_req && steps < 100) begin
            step_line();
            steps++;
            if (inject && steps == 3) begin
                @(negedge clk);
                read_start = 1'b1; rec_valid = 1'b1; print_done = 1'b1;
                @(negedge clk);
                read_start = 1'b0; rec_valid = 1'b0; print_done = 1'b0;
                chk("R11 strobes ignored", feed_req, 1);
            end
        end
        chk({req, " stop line"}, pos, STOP_LINE);
        chk("R5 skip length", steps, want);
        chk("R6 ready at stop", ready, 1);
        exp_arm = 1'b0;
    endtask

    task automatic send_record(input bit sym, input bit with_rs, input string req);
        bit exp_skip = exp_arm && !sym;
        @(negedge clk);
        rec_valid = 1'b1; rec_sym = sym; read_start = with_rs;
        @(negedge clk);
        rec_valid = 1'b0; rec_sym = 1'b0; read_start = 1'b0;
        chk(req, feed_req, (exp_skip || with_rs) ? 1 : 0);
        if (sym) exp_arm = 1'b0;
        if (exp_skip) run_skip(1'b0, req);
        else if (with_rs) begin
            step_line();
            chk(req, feed_req, 0);
        end
    endtask

    task automatic idle_noise(input logic [NCH-1:0] ch);
        @(negedge clk);
        line_step = 1'b1; tape_chan = ch;
        @(negedge clk);
        line_step = 1'b0; tape_chan = '0;
        chk("R9 idle step ignored", ready, 1);
        chk("R9 no motion", feed_req, 0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk("R1 feed after reset", feed_req, 0);
        chk("R1 ready after reset", ready, 1);
        rst_n = 1'b1;

        // Worked case: print body lines, arm at 68, skip to 20.
        while (pos != ARM_LINE) print_advance(1'b1);
        send_record(1'b0, 1'b0, "R4 R6 skip start");
        send_record(1'b0, 1'b0, "R8 disarmed after stop");

        // Feed symbol record takes precedence and disarms.
        goto_line(ARM_LINE - 1);
        print_advance(1'b1);
        send_record(1'b1, 1'b0, "R7 symbol no move");
        send_record(1'b0, 1'b0, "R7 arm cleared");

        // Arm hole without a preceding print cycle.
        goto_line(ARM_LINE - 1);
        print_advance(1'b0);
        send_record(1'b0, 1'b0, "R3 no print no arm");

        // Idle stop hole keeps the arm; skip beats read_start.
        goto_line(ARM_LINE - 1);
        print_advance(1'b1);
        idle_noise(holes(STOP_LINE));
        send_record(1'b0, 1'b1, "R10 R12 skip wins");

        // Idle arm hole does not arm.
        idle_noise(holes(ARM_LINE));
        send_record(1'b0, 1'b0, "R9 idle arm hole");

        // Strobes during a skip are ignored.
        goto_line(ARM_LINE - 1);
        print_advance(1'b1);
        @(negedge clk) begin rec_valid = 1'b1; rec_sym = 1'b0; end
        @(negedge clk) rec_valid = 1'b0;
        chk("R4 skip begins", feed_req, 1);
        run_skip(1'b1, "R11 R6");

        // Random mix of advances, records and idle noise.
        pos = 62;
        for (int i = 0; i < 300; i++) begin
            int kind = int'($urandom_range(0, 9));
            if (kind < 6)      print_advance(1'($urandom_range(0, 3) != 0));
            else if (kind < 9) send_record(1'($urandom_range(0, 2) == 0), 1'b0, "R4 R7 R8 random record");
            else               idle_noise(NCH'($urandom));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule